// File: doc/BRIEF.md
# Two-Channel Bus-Master Register File with Shared Interrupt

This block holds the host-visible bus-master control bytes for a two-channel disk controller. A host reaches a 16-byte window through a simple access port and issues byte, halfword or word accesses. Each channel has a command byte, a status byte and a timing byte. The two channels share one mode byte that records pending interrupts and lets software block them. The command bytes go straight to a DMA engine. A single interrupt line is the OR of the two channels' unblocked pending requests.

Address bit 3 selects the channel. The low three bits select the register in that channel's slice. The DMA engine reports activity and raises error or completion flags through pulse inputs. Each disk channel drives an interrupt level that the mode byte tracks.

Top module: `bm_regfile`

## Requirements
- R1: After reset every register reads 0x00 and `irq_out` is low.
- R2: Only accesses with `acc_size` = 0 (byte) take effect. A read with `acc_size` = 1 returns 0x0000FFFF. A read with `acc_size` = 2 or 3 returns 0xFFFFFFFF. A write of any size other than 0 changes nothing.
- R3: `acc_addr[3]` selects channel 0 or 1. `acc_addr[2:0]` selects the register: 0 command, 1 mode, 2 status, 3 timing. Offsets 4 to 7 of either channel read 0x000000FF and ignore writes. Byte reads return the register in bits 7:0, with bits 31:8 zero.
- R4: A byte write to offset 0 stores all eight bits in that channel's command byte. The command byte drives `cmd_bytes[8n+7:8n]` for channel n.
- R5: In the mode byte, bit 2 is channel-0 pending, bit 3 is channel-1 pending, bit 4 is channel-0 block and bit 5 is channel-1 block. A host write changes only bits 4 and 5. Bits 0, 1, 6 and 7 always read 0.
- R6: Mode bit 2+n equals the `chan_irq[n]` value sampled at the previous clock edge.
- R7: `irq_out` is (pend0 AND NOT block0) OR (pend1 AND NOT block1), taken combinationally from the registered mode byte.
- R8: A status write loads bits 6:5 from the data. It clears bit 1 or bit 2 where the data bit is 1 and keeps it where the data bit is 0. Bit 0 ignores the write. Bits 3, 4 and 7 read 0.
- R9: Offset 1 and offset 9 address the same mode byte, for both reads and writes.
- R10: Status bit 0 of channel n equals the `dma_active[n]` value from the previous edge. A pulse on `dma_err_set[n]` sets status bit 1, and a pulse on `dma_int_set[n]` sets status bit 2. A hardware set wins over a clearing write in the same cycle.
- R11: Each channel has its own timing byte at offset 3, fully writable. A write to one channel's timing byte leaves the other channel's untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte offset in the window |
| acc_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| acc_wdata | input | 8 | Write data for byte writes |
| rd_data | output | 32 | Combinational read data |
| chan_irq | input | 2 | Interrupt level from each disk channel |
| dma_active | input | 2 | DMA engine busy level, per channel |
| dma_err_set | input | 2 | Error-flag set pulse, per channel |
| dma_int_set | input | 2 | Completion-flag set pulse, per channel |
| cmd_bytes | output | 16 | Command bytes, channel 1 in the upper byte |
| irq_out | output | 1 | Shared interrupt level |

## Verification
The assertions check the following on every cycle: pending bits track the channel levels one edge later, the interrupt stays quiet when no channel requests, wide accesses return all ones and write nothing, window holes read 0xFF, and a hardware error set overrides a clearing write. Other behaviours depend on history built up across several accesses, so only the bench's scenarios show them. These are the write-one-to-clear arithmetic, the aliasing of the mode byte at offsets 1 and 9, the independence of the two timing bytes, and block-bit masking as software changes it. The bench also runs random mixes of all these accesses against a reference model.

// File: rtl/bm_regfile.sv
module bm_regfile (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [3:0]  acc_addr,
  input  logic [1:0]  acc_size,
  input  logic [7:0]  acc_wdata,
  output logic [31:0] rd_data,
  input  logic [1:0]  chan_irq,
  input  logic [1:0]  dma_active,
  input  logic [1:0]  dma_err_set,
  input  logic [1:0]  dma_int_set,
  output logic [15:0] cmd_bytes,
  output logic        irq_out
);
  localparam int NCH = 2;

  logic [7:0] cmd_q [NCH];
  logic [7:0] tim_q [NCH];
  logic [7:0] st_q  [NCH];
  logic [1:0] pend_q, blk_q;

  logic       byte_wr;
  logic [2:0] sub;
  logic [7:0] mode_byte;

  assign byte_wr   = acc_valid & acc_write & (acc_size == 2'd0);
  assign sub       = acc_addr[2:0];
  assign mode_byte = {2'b00, blk_q, pend_q, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      blk_q  <= '0;
    end else begin
      pend_q <= chan_irq;
      if (byte_wr && sub == 3'd1) blk_q <= acc_wdata[5:4];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel, wr_cmd, wr_st, wr_tim;
    assign sel    = byte_wr && (acc_addr[3] == 1'(c));
    assign wr_cmd = sel && sub == 3'd0;
    assign wr_st  = sel && sub == 3'd2;
    assign wr_tim = sel && sub == 3'd3;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmd_q[c] <= '0;
        tim_q[c] <= '0;
        st_q[c]  <= '0;
      end else begin
        if (wr_cmd) cmd_q[c] <= acc_wdata;
        if (wr_tim) tim_q[c] <= acc_wdata;
        st_q[c][0]   <= dma_active[c];
        st_q[c][1]   <= dma_err_set[c] | (st_q[c][1] & ~(wr_st & acc_wdata[1]));
        st_q[c][2]   <= dma_int_set[c] | (st_q[c][2] & ~(wr_st & acc_wdata[2]));
        st_q[c][4:3] <= 2'b00;
        if (wr_st) st_q[c][6:5] <= acc_wdata[6:5];
        st_q[c][7]   <= 1'b0;
      end
    end

    assign cmd_bytes[8*c +: 8] = cmd_q[c];
  end

  assign irq_out = |(pend_q & ~blk_q);

  always_comb begin
    logic [7:0] b;
    logic       ch;
    ch = acc_addr[3];
    case (sub)
      3'd0:    b = cmd_q[ch];
      3'd1:    b = mode_byte;
      3'd2:    b = st_q[ch];
      3'd3:    b = tim_q[ch];
      default: b = 8'hFF;
    endcase
    case (acc_size)
      2'd0:    rd_data = {24'h0, b};
      2'd1:    rd_data = 32'h0000FFFF;
      default: rd_data = 32'hFFFFFFFF;
    endcase
  end
endmodule

module bm_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [3:0]  acc_addr,
  input logic [1:0]  acc_size,
  input logic [31:0] rd_data,
  input logic [1:0]  chan_irq,
  input logic [1:0]  dma_err_set,
  input logic [15:0] cmd_bytes,
  input logic        irq_out,
  input logic [1:0]  pend_q,
  input logic [7:0]  st0
);
  // R6
  pend_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend_q == $past(chan_irq));

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_irq == 2'b00 |=> !irq_out);

  // R2
  wide_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_write && acc_size[1] |-> rd_data == 32'hFFFFFFFF);

  // R2
  wide_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_write && acc_size != 2'd0 |=> $stable(cmd_bytes));

  // R3
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_write && acc_size == 2'd0 && acc_addr[2] |-> rd_data == 32'h000000FF);

  // R10
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_err_set[0] |=> st0[1]);
endmodule

bind bm_regfile bm_regfile_chk chk_i (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_size(acc_size), .rd_data(rd_data),
  .chan_irq(chan_irq), .dma_err_set(dma_err_set), .cmd_bytes(cmd_bytes),
  .irq_out(irq_out), .pend_q(pend_q), .st0(st_q[0])
);

// File: tb/tb_bm_regfile.sv
module tb_bm_regfile;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        acc_valid = 0, acc_write = 0;
  logic [3:0]  acc_addr = 0;
  logic [1:0]  acc_size = 0;
  logic [7:0]  acc_wdata = 0;
  logic [31:0] rd_data;
  logic [1:0]  chan_irq = 0, dma_active = 0, dma_err_set = 0, dma_int_set = 0;
  logic [15:0] cmd_bytes;
  logic        irq_out;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_cmd [2];
  logic [7:0] m_tim [2];
  logic [7:0] m_st  [2];
  logic [1:0] m_pend, m_blk;

  bm_regfile dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [3:0] a, logic [1:0] sz);
    logic [7:0] b;
    if (sz == 2'd1) return 32'h0000FFFF;
    if (sz != 2'd0) return 32'hFFFFFFFF;
    case (a[2:0])
      3'd0: b = m_cmd[a[3]];
      3'd1: b = {2'b00, m_blk, m_pend, 2'b00};
      3'd2: b = m_st[a[3]];
      3'd3: b = m_tim[a[3]];
      default: b = 8'hFF;
    endcase
    return {24'h0, b};
  endfunction

  task automatic cyc(bit v, bit w, logic [3:0] a, logic [1:0] sz, logic [7:0] d,
                     logic [1:0] irqv, logic [1:0] act, logic [1:0] es, logic [1:0] is,
                     string tag);
    acc_valid = v; acc_write = w; acc_addr = a; acc_size = sz; acc_wdata = d;
    chan_irq = irqv; dma_active = act; dma_err_set = es; dma_int_set = is;
    @(negedge clk);
    if (v && !w) chk(tag, rd_data, exp_read(a, sz));
    chk("R7", {31'b0, irq_out}, {31'b0, |(m_pend & ~m_blk)});
    chk("R4", {16'b0, cmd_bytes}, {16'b0, m_cmd[1], m_cmd[0]});
    @(posedge clk);
    #1;
    for (int c = 0; c < 2; c++) begin
      logic ws;
      ws = v && w && sz == 2'd0 && a[3] == 1'(c) && a[2:0] == 3'd2;
      m_st[c] = {1'b0, ws ? d[6:5] : m_st[c][6:5], 2'b00,
                 is[c] | (m_st[c][2] & ~(ws & d[2])),
                 es[c] | (m_st[c][1] & ~(ws & d[1])),
                 act[c]};
      if (v && w && sz == 2'd0 && a[3] == 1'(c)) begin
        if (a[2:0] == 3'd0) m_cmd[c] = d;
        if (a[2:0] == 3'd3) m_tim[c] = d;
      end
    end
    if (v && w && sz == 2'd0 && a[2:0] == 3'd1) m_blk = d[5:4];
    m_pend = irqv;
  endtask

  task automatic rd(logic [3:0] a, string tag, logic [1:0] irqv = 0);
    cyc(1, 0, a, 0, 0, irqv, 0, 0, 0, tag);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d, string tag, logic [1:0] irqv = 0);
    cyc(1, 1, a, 0, d, irqv, 0, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int c = 0; c < 2; c++) begin m_cmd[c] = 0; m_tim[c] = 0; m_st[c] = 0; end
    m_pend = 0; m_blk = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 16; a++) rd(4'(a), "R1");

    // R4 command bytes
    wr(4'h0, 8'hA5, "R4"); wr(4'h8, 8'h3C, "R4");
    rd(4'h0, "R4"); rd(4'h8, "R4");

    // R2 wide accesses
    cyc(1, 0, 4'h0, 2'd1, 0, 0, 0, 0, 0, "R2");
    cyc(1, 0, 4'h8, 2'd2, 0, 0, 0, 0, 0, "R2");
    cyc(1, 1, 4'h0, 2'd1, 8'h11, 0, 0, 0, 0, "R2");
    cyc(1, 1, 4'h3, 2'd2, 8'h22, 0, 0, 0, 0, "R2");
    rd(4'h0, "R2"); rd(4'h3, "R2");

    // R3 holes
    wr(4'h5, 8'h00, "R3"); rd(4'h5, "R3"); rd(4'hC, "R3");

    // R5 / R9 mode write masking and aliasing
    wr(4'h1, 8'hFF, "R5"); rd(4'h1, "R5"); rd(4'h9, "R9");
    wr(4'h9, 8'h10, "R9"); rd(4'h1, "R9");

    // R6 / R7 pending and blocking
    rd(4'h1, "R6", 2'b11); rd(4'h9, "R6", 2'b11);
    wr(4'h1, 8'h30, "R7", 2'b11); rd(4'h1, "R7", 2'b01);
    wr(4'h1, 8'h20, "R7", 2'b01); rd(4'h1, "R7", 2'b01);
    rd(4'h1, "R6", 2'b10); rd(4'h1, "R7", 2'b00); rd(4'h1, "R7", 2'b00);

    // R10 hardware sets and priority
    cyc(0, 0, 0, 0, 0, 0, 2'b01, 2'b01, 2'b10, "R10");
    rd(4'h2, "R10"); rd(4'hA, "R10");
    cyc(1, 1, 4'h2, 0, 8'h06, 0, 0, 2'b01, 2'b00, "R10");
    rd(4'h2, "R10");

    // R8 status write rules
    wr(4'h2, 8'hFF, "R8"); rd(4'h2, "R8");
    wr(4'hA, 8'h04, "R8"); rd(4'hA, "R8");
    cyc(1, 1, 4'h2, 0, 8'h01, 0, 2'b01, 0, 0, "R8"); rd(4'h2, "R8");

    // R11 timing independence
    wr(4'h3, 8'h5A, "R11"); rd(4'hB, "R11"); wr(4'hB, 8'hC3, "R11");
    rd(4'h3, "R11"); rd(4'hB, "R11");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] sz;
      logic [3:0] a;
      sz = ($urandom % 4 == 0) ? 2'($urandom) : 2'd0;
      a  = 4'($urandom);
      cyc($urandom % 4 != 0, 1'($urandom), a, sz, 8'($urandom),
          2'($urandom), 2'($urandom),
          ($urandom % 8 == 0) ? 2'($urandom) : 2'b00,
          ($urandom % 8 == 0) ? 2'($urandom) : 2'b00,
          a[2] ? "R3" : (sz != 0 ? "R2" : "R8"));
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    finish_run();
  end
endmodule